// File: doc/BRIEF.md
# I/O Port Address Router

This block sits behind the load/store path of a core and turns I/O-space accesses into physical-address requests. Each request carries a port number, an access size code, a write flag and write data. The block returns a routed physical address and a target code. The target code selects one of four destinations: the block's own 32-bit configuration-address register, the PCI configuration window, the generic I/O window, or nothing (dropped). The configuration-address register follows the usual two-port scheme. A 4-byte access to port 0xCF8 reaches the register. Accesses to ports 0xCFC through 0xCFF are steered into the PCI configuration window using the latched register contents.

A second, independent path checks physical addresses against a 4 KiB interrupt-controller window. The window base comes in on an input. A hit is redirected to a fixed prefix plus its offset inside the window, and the result is flagged uncacheable. A miss passes through unchanged.

Both paths register their results, so every response appears one clock after its request.

Top module: `iort_router`

## Requirements
- R1: After reset (synchronous, active high), both response valids are low and the configuration-address register reads back as 0.
- R2: A request whose port input has any bit above bit 15 set responds with error high, target DROP (code 3), address 0 and read data all ones. The configuration register is not changed.
- R3: A request to port 0xCF8 with size code 2 (4 bytes; the codes are 0=1 B, 1=2 B, 2=4 B, 3=8 B) has target CFGREG (code 0) and address 0. A read returns the register. A write loads the register at that clock edge and returns data 0.
- R4: A request to port 0xCF8 with any size code other than 2 has target IOSPACE (code 2) and address IO_PREFIX | 0xCF8.
- R5: Ports 0xCFC–0xCFF are matched on port bits 15:2. When register bit 31 is set, the target is PCICFG (code 1) and the address is PCI_PREFIX | {register bits 30:2, port bits 1:0}.
- R6: A 0xCFC–0xCFF request with register bit 31 clear has target DROP and read data all ones. A write of this kind leaves the register unchanged.
- R7: Every other in-range port has target IOSPACE and address IO_PREFIX | port, with read data 0.
- R8: Each I/O response is valid exactly one cycle after its request, and only then.
- R9: A physical address whose bits above 11 equal those of the window base is redirected to APIC_PREFIX | address bits 11:0 and flagged uncacheable. Any other address passes through unchanged and cacheable. Results are valid one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | I/O request strobe |
| io_port | input | IN_W | Port number (bits above 15 must be zero) |
| io_size | input | 2 | Access size code, log2 of bytes |
| io_write | input | 1 | Write when high |
| io_wdata | input | 32 | Write data |
| io_rsp_valid | output | 1 | I/O response strobe |
| io_rsp_target | output | 2 | 0 CFGREG, 1 PCICFG, 2 IOSPACE, 3 DROP |
| io_rsp_addr | output | PA_W | Routed physical address |
| io_rsp_rdata | output | 32 | Read data for internally answered requests |
| io_rsp_err | output | 1 | Port out of 16-bit range |
| ph_valid | input | 1 | Physical request strobe |
| ph_addr | input | PA_W | Physical address |
| apic_base | input | PA_W | Interrupt-controller window base (bits 11:0 ignored) |
| ph_rsp_valid | output | 1 | Physical response strobe |
| ph_rsp_addr | output | PA_W | Redirected or passed-through address |
| ph_rsp_uncached | output | 1 | High on a window hit |

## Verification
Each I/O result, and each physical-window result, is due in the first cycle after the clock edge that samples its request. The bench drives a request on a falling edge. It removes the request on the next falling edge and compares the outputs there, which is after the only edge that could have updated them. A write to the configuration register takes effect at that same edge. The bench therefore uses its updated register model only from the following request onward, and it reads the register back through a 4-byte read of 0xCF8 to check that dropped writes left it alone.

// File: rtl/iort_pkg.sv
package iort_pkg;

  typedef enum logic [1:0] {
    TGT_CFGREG  = 2'd0,
    TGT_PCICFG  = 2'd1,
    TGT_IOSPACE = 2'd2,
    TGT_DROP    = 2'd3
  } tgt_e;

  localparam logic [1:0]  SIZE_4B       = 2'd2;
  localparam logic [15:0] PORT_CFG_ADDR = 16'h0CF8;
  localparam logic [15:0] PORT_CFG_DATA = 16'h0CFC;
  localparam int          CFG_W         = 32;

endpackage

// File: rtl/iort_cfg_reg.sv
module iort_cfg_reg
  import iort_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/iort_port_decode.sv
module iort_port_decode
  import iort_pkg::*;
#(
  parameter int             IN_W       = 32,
  parameter int             PA_W       = 32,
  parameter logic [PA_W-1:0] PCI_PREFIX = 32'hC000_0000,
  parameter logic [PA_W-1:0] IO_PREFIX  = 32'h8000_0000
) (
  input  logic [IN_W-1:0]   port_in,
  input  logic [1:0]        size,
  input  logic [CFG_W-1:0]  cfg_q,
  output tgt_e              tgt,
  output logic [PA_W-1:0]   addr,
  output logic              err,
  output logic              cfg_hit
);

  localparam int PORT_W = 16;

  logic              out_of_range;
  logic [PORT_W-1:0] port;
  logic              data_win;

  generate
    if (IN_W > PORT_W) begin : g_wide
      assign out_of_range = |port_in[IN_W-1:PORT_W];
    end else begin : g_narrow
      assign out_of_range = 1'b0;
    end
  endgenerate

  assign port     = port_in[PORT_W-1:0];
  assign data_win = (port[PORT_W-1:2] == PORT_CFG_DATA[PORT_W-1:2]);

  always_comb begin
    tgt     = TGT_IOSPACE;
    addr    = IO_PREFIX | PA_W'(port);
    err     = 1'b0;
    cfg_hit = 1'b0;
    if (out_of_range) begin
      tgt  = TGT_DROP;
      addr = '0;
      err  = 1'b1;
    end else if (port == PORT_CFG_ADDR && size == SIZE_4B) begin
      tgt     = TGT_CFGREG;
      addr    = '0;
      cfg_hit = 1'b1;
    end else if (data_win) begin
      if (cfg_q[CFG_W-1]) begin
        tgt  = TGT_PCICFG;
        addr = PCI_PREFIX | PA_W'({cfg_q[CFG_W-2:2], port[1:0]});
      end else begin
        tgt  = TGT_DROP;
        addr = '0;
      end
    end
  end

endmodule

// File: rtl/iort_apic_window.sv
module iort_apic_window #(
  parameter int              PA_W        = 32,
  parameter int              PG_W        = 12,
  parameter logic [PA_W-1:0] APIC_PREFIX = 32'hA000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [PA_W-1:0] in_addr,
  input  logic [PA_W-1:0] base,
  output logic            out_valid,
  output logic [PA_W-1:0] out_addr,
  output logic            out_uncached
);

  logic hit;
  assign hit = (in_addr[PA_W-1:PG_W] == base[PA_W-1:PG_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_uncached <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_uncached <= in_valid && hit;
      if (hit) out_addr <= APIC_PREFIX | PA_W'(in_addr[PG_W-1:0]);
      else     out_addr <= in_addr;
    end
  end

  // R9: a redirected result lands inside the prefix page
  a_r9_redirect_prefix: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_uncached) |-> (out_addr[PA_W-1:PG_W] == APIC_PREFIX[PA_W-1:PG_W]));

  // R9: a non-hit passes the requested address through untouched
  a_r9_pass_through: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(in_addr[PA_W-1:PG_W] == base[PA_W-1:PG_W])) |=>
      (out_valid && !out_uncached && out_addr == $past(in_addr)));

endmodule

// File: rtl/iort_router.sv
module iort_router
  import iort_pkg::*;
#(
  parameter int              IN_W        = 32,
  parameter int              PA_W        = 32,
  parameter logic [PA_W-1:0] PCI_PREFIX  = 32'hC000_0000,
  parameter logic [PA_W-1:0] IO_PREFIX   = 32'h8000_0000,
  parameter logic [PA_W-1:0] APIC_PREFIX = 32'hA000_0000,
  parameter int              PG_W        = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            io_valid,
  input  logic [IN_W-1:0] io_port,
  input  logic [1:0]      io_size,
  input  logic            io_write,
  input  logic [31:0]     io_wdata,
  output logic            io_rsp_valid,
  output logic [1:0]      io_rsp_target,
  output logic [PA_W-1:0] io_rsp_addr,
  output logic [31:0]     io_rsp_rdata,
  output logic            io_rsp_err,
  input  logic            ph_valid,
  input  logic [PA_W-1:0] ph_addr,
  input  logic [PA_W-1:0] apic_base,
  output logic            ph_rsp_valid,
  output logic [PA_W-1:0] ph_rsp_addr,
  output logic            ph_rsp_uncached
);

  logic [CFG_W-1:0] cfg_q;
  tgt_e             dec_tgt;
  logic [PA_W-1:0]  dec_addr;
  logic             dec_err;
  logic             dec_cfg_hit;
  logic             cfg_we;
  logic [31:0]      rdata_nxt;

  iort_port_decode #(
    .IN_W(IN_W), .PA_W(PA_W), .PCI_PREFIX(PCI_PREFIX), .IO_PREFIX(IO_PREFIX)
  ) u_decode (
    .port_in(io_port), .size(io_size), .cfg_q(cfg_q),
    .tgt(dec_tgt), .addr(dec_addr), .err(dec_err), .cfg_hit(dec_cfg_hit)
  );

  assign cfg_we = io_valid && io_write && dec_cfg_hit;

  iort_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(io_wdata), .q(cfg_q)
  );

  always_comb begin
    unique case (dec_tgt)
      TGT_DROP:   rdata_nxt = '1;
      TGT_CFGREG: rdata_nxt = io_write ? 32'd0 : cfg_q;
      default:    rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rsp_valid  <= 1'b0;
      io_rsp_target <= TGT_DROP;
      io_rsp_addr   <= '0;
      io_rsp_rdata  <= '0;
      io_rsp_err    <= 1'b0;
    end else begin
      io_rsp_valid <= io_valid;
      if (io_valid) begin
        io_rsp_target <= dec_tgt;
        io_rsp_addr   <= dec_addr;
        io_rsp_rdata  <= rdata_nxt;
        io_rsp_err    <= dec_err;
      end
    end
  end

  iort_apic_window #(
    .PA_W(PA_W), .PG_W(PG_W), .APIC_PREFIX(APIC_PREFIX)
  ) u_apic (
    .clk(clk), .rst(rst), .in_valid(ph_valid), .in_addr(ph_addr), .base(apic_base),
    .out_valid(ph_rsp_valid), .out_addr(ph_rsp_addr), .out_uncached(ph_rsp_uncached)
  );

  // R8: one response per request, one cycle later
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
    io_valid |=> io_rsp_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !io_valid |=> !io_rsp_valid);

  // R2: an out-of-range port is always dropped
  a_r2_err_drops: assert property (@(posedge clk) disable iff (rst)
    (io_rsp_valid && io_rsp_err) |-> (io_rsp_target == TGT_DROP && io_rsp_rdata == '1));

  // R6: the register only moves on a 4-byte in-range write to 0xCF8
  a_r6_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    !(io_valid && io_write && io_size == SIZE_4B && (io_port >> 16) == 0 &&
      io_port[15:0] == PORT_CFG_ADDR) |=> $stable(cfg_q));

  // R5: the PCI window is chosen only while the enable bit was set
  a_r5_pci_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (io_valid && (io_port >> 16) == 0 && io_port[15:2] == PORT_CFG_DATA[15:2] && !cfg_q[31])
      |=> (io_rsp_target == TGT_DROP));

endmodule

// File: tb/iort_router_tb_top.sv
`timescale 1ns/1ps
module iort_router_tb_top;

  localparam int IN_W = 32;
  localparam int PA_W = 32;
  localparam logic [31:0] PCI_P  = 32'hC000_0000;
  localparam logic [31:0] IO_P   = 32'h8000_0000;
  localparam logic [31:0] APIC_P = 32'hA000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_valid = 1'b0;
  logic [IN_W-1:0] io_port = '0;
  logic [1:0] io_size = '0;
  logic io_write = 1'b0;
  logic [31:0] io_wdata = '0;
  logic io_rsp_valid;
  logic [1:0] io_rsp_target;
  logic [PA_W-1:0] io_rsp_addr;
  logic [31:0] io_rsp_rdata;
  logic io_rsp_err;
  logic ph_valid = 1'b0;
  logic [PA_W-1:0] ph_addr = '0;
  logic [PA_W-1:0] apic_base = 32'hFEE0_0000;
  logic ph_rsp_valid;
  logic [PA_W-1:0] ph_rsp_addr;
  logic ph_rsp_uncached;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] cfg_m = '0;

  always #2.5 clk = ~clk;

  iort_router dut_i (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_port(io_port), .io_size(io_size),
    .io_write(io_write), .io_wdata(io_wdata), .io_rsp_valid(io_rsp_valid),
    .io_rsp_target(io_rsp_target), .io_rsp_addr(io_rsp_addr), .io_rsp_rdata(io_rsp_rdata),
    .io_rsp_err(io_rsp_err), .ph_valid(ph_valid), .ph_addr(ph_addr), .apic_base(apic_base),
    .ph_rsp_valid(ph_rsp_valid), .ph_rsp_addr(ph_rsp_addr), .ph_rsp_uncached(ph_rsp_uncached)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected I/O response from the requirements
  task automatic exp_io(input logic [31:0] p, input logic [1:0] sz, input bit wr,
                        output logic [1:0] tgt, output logic [31:0] addr,
                        output logic [31:0] rd, output bit err, output string req);
    err = 1'b0;
    if (p[31:16] != 0) begin
      tgt = 2'd3; addr = 0; rd = '1; err = 1'b1; req = "R2";
    end else if (p[15:0] == 16'h0CF8 && sz == 2'd2) begin
      tgt = 2'd0; addr = 0; rd = wr ? 32'd0 : cfg_m; req = "R3";
    end else if (p[15:2] == 14'h033F) begin
      if (cfg_m[31]) begin
        tgt = 2'd1; addr = PCI_P | {1'b0, cfg_m[30:2], p[1:0]}; rd = 0; req = "R5";
      end else begin
        tgt = 2'd3; addr = 0; rd = '1; req = "R6";
      end
    end else begin
      tgt = 2'd2; addr = IO_P | {16'd0, p[15:0]}; rd = 0;
      req = (p[15:0] == 16'h0CF8) ? "R4" : "R7";
    end
  endtask

  task automatic do_io(input logic [31:0] p, input logic [1:0] sz, input bit wr, input logic [31:0] wd);
    logic [1:0] et; logic [31:0] ea; logic [31:0] er; bit ee; string rq;
    exp_io(p, sz, wr, et, ea, er, ee, rq);
    io_valid = 1'b1; io_port = p; io_size = sz; io_write = wr; io_wdata = wd;
    @(negedge clk);
    io_valid = 1'b0;
    chk(io_rsp_valid === 1'b1, "R8 valid", {63'd0, io_rsp_valid}, 64'd1);
    chk(io_rsp_target === et, rq, {62'd0, io_rsp_target}, {62'd0, et});
    chk(io_rsp_addr === ea, rq, {32'd0, io_rsp_addr}, {32'd0, ea});
    chk(io_rsp_rdata === er, rq, {32'd0, io_rsp_rdata}, {32'd0, er});
    chk(io_rsp_err === ee, rq, {63'd0, io_rsp_err}, {63'd0, ee});
    if (wr && p[31:16] == 0 && p[15:0] == 16'h0CF8 && sz == 2'd2) cfg_m = wd;
    @(negedge clk);
    chk(io_rsp_valid === 1'b0, "R8 idle", {63'd0, io_rsp_valid}, 64'd0);
  endtask

  task automatic do_ph(input logic [31:0] a);
    bit hit; logic [31:0] ea;
    hit = (a[31:12] == apic_base[31:12]);
    ea = hit ? (APIC_P | {20'd0, a[11:0]}) : a;
    ph_valid = 1'b1; ph_addr = a;
    @(negedge clk);
    ph_valid = 1'b0;
    chk(ph_rsp_valid === 1'b1, "R9 valid", {63'd0, ph_rsp_valid}, 64'd1);
    chk(ph_rsp_addr === ea, "R9 addr", {32'd0, ph_rsp_addr}, {32'd0, ea});
    chk(ph_rsp_uncached === hit, "R9 uncached", {63'd0, ph_rsp_uncached}, {63'd0, hit});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(io_rsp_valid === 1'b0, "R1 io valid", {63'd0, io_rsp_valid}, 64'd0);
    chk(ph_rsp_valid === 1'b0, "R1 ph valid", {63'd0, ph_rsp_valid}, 64'd0);
    do_io(32'h0CF8, 2'd2, 1'b0, 0);                  // R1 register reads 0
    // R6 disabled data window, write ignored
    do_io(32'h0CFD, 2'd0, 1'b0, 0);
    do_io(32'h0CFC, 2'd2, 1'b1, 32'h1234_5678);
    do_io(32'h0CF8, 2'd2, 1'b0, 0);                  // R6 readback still 0
    // R3 write then readback
    do_io(32'h0CF8, 2'd2, 1'b1, 32'h8012_3458);
    do_io(32'h0CF8, 2'd2, 1'b0, 0);
    // R5 all four data ports
    for (int k = 0; k < 4; k++) do_io(32'h0CFC + k, 2'd0, 1'b0, 0);
    // R4 narrow config-address accesses
    do_io(32'h0CF8, 2'd0, 1'b1, 32'hFFFF_FFFF);
    do_io(32'h0CF8, 2'd1, 1'b0, 0);
    do_io(32'h0CF8, 2'd3, 1'b0, 0);
    do_io(32'h0CF8, 2'd2, 1'b0, 0);                  // R4 register unchanged
    // R2 out-of-range, including a 4-byte write to an aliasing port
    do_io(32'h0001_0CF8, 2'd2, 1'b1, 32'h0);
    do_io(32'h8000_0CFC, 2'd0, 1'b0, 0);
    do_io(32'h0CF8, 2'd2, 1'b0, 0);
    // R7 edges
    do_io(32'h0000, 2'd0, 1'b0, 0);
    do_io(32'hFFFF, 2'd1, 1'b0, 0);
    do_io(32'h0CFB, 2'd0, 1'b0, 0);
    do_io(32'h0D00, 2'd0, 1'b0, 0);
    // R9 window boundaries
    do_ph(32'hFEDF_FFFF);
    do_ph(32'hFEE0_0000);
    do_ph(32'hFEE0_0FFF);
    do_ph(32'hFEE0_1000);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] p; logic [1:0] sz; bit wr;
      sz = 2'($urandom % 4); wr = 1'($urandom % 2);
      case ($urandom % 6)
        0: begin p = 32'h0CF8; sz = 2'd2; end
        1: p = 32'h0CFC + ($urandom % 4);
        2: p = {16'd0, 16'($urandom)};
        3: p = $urandom | 32'h0001_0000;
        4: p = 32'h0CF8;
        default: p = 32'h0CF8 + ($urandom % 8);
      endcase
      do_io(p, sz, wr, $urandom);
      if (i % 8 == 0) begin
        apic_base = $urandom;
        do_ph({apic_base[31:12], 12'($urandom)});
        do_ph($urandom);
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule